// File: doc/BRIEF.md
# Unaligned Buffer Transfer Splitter

The splitter moves a byte buffer of arbitrary start address and length between memory and a fixed-width 32-bit device data port. It turns the request into a chain of byte, halfword and word accesses so that an unaligned buffer is first brought to a word boundary. The bulk then moves as whole words, and any leftover bytes are handled at the end. A host pulses `go` with the address, the length and the direction. The block then runs one access at a time on a request/acknowledge port and pulses `done` when the buffer has been covered.

Memory is seen through a word-wide window. For a write to the device, the block reads the buffer word that holds the current address from `buf_word` and moves the needed bytes down to the low lanes of `acc_wdata`. For a read from the device, it takes the low lanes of `acc_rdata` and moves them up to the byte lanes of the buffer address, with byte enables on `buf_be`. The same access order is used in both directions.

Top module: `xfer_splitter`

## Requirements
- R1: When the current address is odd and at least one byte remains, the next access is a byte access (size code 0). After it, the address rises by 1 and the remaining count falls by 1.
- R2: When the current address is even but not a multiple of 4 and at least two bytes remain, the next access is a halfword access (size code 1). The address rises by 2.
- R3: At a word-aligned address with four or more bytes left, word accesses (size code 2) follow one another, and each one advances the address by 4.
- R4: At a word-aligned address with fewer than four bytes left, a halfword access is issued if two or more remain, and then a single byte access if one remains.
- R5: `acc_addr` carries the buffer address of the current access. The first access uses `go_addr`, and every later access starts where the previous one ended.
- R6: On device writes, lane i of `acc_wdata` (bits 8i+7..8i) holds the buffer byte at `acc_addr`+i, taken from `buf_word`, whose lane k holds the byte at word address + k. Lanes at or beyond the access size are zero.
- R7: On device reads, the acknowledge cycle raises `buf_we`. Byte n of `acc_rdata` (lane n) goes to lane `acc_addr[1:0]`+n of `buf_wdata`, with the matching bits of `buf_be` set and all other enables clear. `buf_we` stays low on device writes.
- R8: The split sequence and addresses do not depend on `go_wr`, and `acc_wr` reflects the direction that was captured.
- R9: A request of length zero issues no access and raises `done` in the cycle after `go` is sampled.
- R10: Only one access is outstanding. `acc_req` and the access fields hold until the cycle in which `acc_ack` is sampled high. If bytes remain, the next access is presented in the following cycle.
- R11: `done` is a one-cycle pulse in the cycle after the final acknowledge. `acc_req` is low in that cycle, and `busy` is high only while accesses are pending.
- R12: A `go` pulse that arrives while a transfer is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe |
| go_wr | input | 1 | Direction: 1 = buffer to device, 0 = device to buffer |
| go_addr | input | AW | Buffer start address |
| go_len | input | LW | Buffer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_req | output | 1 | Access request valid |
| acc_wr | output | 1 | Access direction |
| acc_size | output | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | output | AW | Buffer address of the access |
| acc_wdata | output | 32 | Device write data, low-lane aligned |
| acc_ack | input | 1 | Access acknowledge |
| acc_rdata | input | 32 | Device read data, low-lane aligned |
| buf_word | input | 32 | Buffer word holding acc_addr |
| buf_wdata | output | 32 | Buffer write data in address lanes |
| buf_be | output | 4 | Buffer byte enables |
| buf_we | output | 1 | Buffer write strobe |

## Verification
The first access is due in the cycle after the edge that samples `go`. Each following access is due in the cycle after the edge that samples `acc_ack`, and `done` is due one cycle after the last acknowledge, or one cycle after `go` for zero length. The write-lane and read-lane outputs are combinational in the access fields and `acc_ack`, so they are valid in the cycle the access is shown. The bench drives and samples on the falling edge, checks every newly shown access in the first falling edge after the edge that produced it, and inserts zero to two wait cycles so that holding behaviour is exercised as well.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;

    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_e;

    // number of bytes moved by one access of the given size
    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            SZ_HALF: size_bytes = 3'd2;
            SZ_WORD: size_bytes = 3'd4;
            default: size_bytes = 3'd1;
        endcase
    endfunction

    // alignment-driven size choice: odd address forces a byte,
    // half-aligned address with room takes a halfword, then words,
    // then the tail halfword and tail byte
    function automatic acc_size_e choose_size(logic [1:0] lo,
                                              logic       ge2,
                                              logic       ge4);
        if (lo[0])
            choose_size = SZ_BYTE;
        else if (lo[1])
            choose_size = ge2 ? SZ_HALF : SZ_BYTE;
        else if (ge4)
            choose_size = SZ_WORD;
        else if (ge2)
            choose_size = SZ_HALF;
        else
            choose_size = SZ_BYTE;
    endfunction

endpackage

// File: rtl/xs_size_pick.sv
module xs_size_pick
    import xfer_split_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic [1:0]    addr_lo,
    input  logic [LW-1:0] remain,
    output acc_size_e     size,
    output logic [2:0]    step
);
    logic ge2, ge4;

    assign ge2  = (remain >= LW'(2));
    assign ge4  = (remain >= LW'(4));
    assign size = choose_size(addr_lo, ge2, ge4);
    assign step = size_bytes(size);

endmodule

// File: rtl/xs_lane_steer.sv
module xs_lane_steer
    import xfer_split_pkg::*;
(
    input  logic [1:0]       addr_lo,
    input  logic [2:0]       step,
    input  logic [DW-1:0]    buf_word,
    input  logic [DW-1:0]    acc_rdata,
    output logic [DW-1:0]    acc_wdata,
    output logic [DW-1:0]    buf_wdata,
    output logic [LANES-1:0] buf_be
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // write side: device lane i takes buffer byte at offset i
        logic [1:0] src_lane;
        logic       w_on;
        assign src_lane = 2'(i) + addr_lo;
        assign w_on     = (3'(i) < step);
        assign acc_wdata[8*i +: 8] = w_on ? buf_word[8*src_lane +: 8] : 8'h00;

        // read side: buffer lane i takes device lane (i - offset)
        logic [2:0] rel;
        logic [1:0] dev_lane;
        logic       r_on;
        assign rel      = 3'(i) - {1'b0, addr_lo};
        assign dev_lane = rel[1:0];
        assign r_on     = (3'(i) >= {1'b0, addr_lo}) && (rel < step);
        assign buf_be[i] = r_on;
        assign buf_wdata[8*i +: 8] = r_on ? acc_rdata[8*dev_lane +: 8] : 8'h00;
    end

endmodule

// File: rtl/xs_ctrl.sv
module xs_ctrl
    import xfer_split_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          go_wr,
    input  logic [AW-1:0] go_addr,
    input  logic [LW-1:0] go_len,
    input  logic          acc_ack,
    input  logic [2:0]    step,
    output logic [AW-1:0] cur_addr,
    output logic [LW-1:0] remain,
    output logic          run,
    output logic          wr_q,
    output logic          done_q
);
    ctrl_state_e state;
    logic        last_step;

    assign run       = (state == ST_RUN);
    assign last_step = (remain == LW'(step));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            wr_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        cur_addr <= go_addr;
                        remain   <= go_len;
                        wr_q     <= go_wr;
                        if (go_len == '0)
                            done_q <= 1'b1;
                        else
                            state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (acc_ack) begin
                        cur_addr <= cur_addr + AW'(step);
                        remain   <= remain - LW'(step);
                        if (last_step) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a pending access holds its address and count until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !acc_ack) |=> (run && $stable(cur_addr) && $stable(remain)));

    // R9: zero-length start completes at once with no access
    a_r9_zero_len: assert property (@(posedge clk) disable iff (rst)
        (!run && go && go_len == '0) |=> (done_q && !run));

    // R11: done follows the final acknowledge and never overlaps a request
    a_r11_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (run && acc_ack && last_step) |=> (done_q && !run));
    a_r11_done_clean: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run);

    // R12: a start strobe during a transfer leaves the captured request alone
    a_r12_ignore_go: assert property (@(posedge clk) disable iff (rst)
        (run && go && !acc_ack) |=> ($stable(cur_addr) && $stable(remain) && $stable(wr_q)));

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xfer_split_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_wr,
    input  logic [AW-1:0]    go_addr,
    input  logic [LW-1:0]    go_len,
    output logic             busy,
    output logic             done,
    output logic             acc_req,
    output logic             acc_wr,
    output logic [1:0]       acc_size,
    output logic [AW-1:0]    acc_addr,
    output logic [DW-1:0]    acc_wdata,
    input  logic             acc_ack,
    input  logic [DW-1:0]    acc_rdata,
    input  logic [DW-1:0]    buf_word,
    output logic [DW-1:0]    buf_wdata,
    output logic [LANES-1:0] buf_be,
    output logic             buf_we
);
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] remain;
    logic          run, wr_q, done_q;
    acc_size_e     size;
    logic [2:0]    step;

    xs_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .go_wr    (go_wr),
        .go_addr  (go_addr),
        .go_len   (go_len),
        .acc_ack  (acc_ack),
        .step     (step),
        .cur_addr (cur_addr),
        .remain   (remain),
        .run      (run),
        .wr_q     (wr_q),
        .done_q   (done_q)
    );

    xs_size_pick #(.LW(LW)) u_pick (
        .addr_lo (cur_addr[1:0]),
        .remain  (remain),
        .size    (size),
        .step    (step)
    );

    xs_lane_steer u_steer (
        .addr_lo   (cur_addr[1:0]),
        .step      (step),
        .buf_word  (buf_word),
        .acc_rdata (acc_rdata),
        .acc_wdata (acc_wdata),
        .buf_wdata (buf_wdata),
        .buf_be    (buf_be)
    );

    assign busy     = run;
    assign done     = done_q;
    assign acc_req  = run;
    assign acc_wr   = wr_q;
    assign acc_size = size;
    assign acc_addr = cur_addr;
    assign buf_we   = run && acc_ack && !wr_q;

    // R3: word accesses only at word-aligned addresses
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_size == SZ_WORD) |-> (acc_addr[1:0] == 2'b00));

    // R2: halfword accesses only at even addresses
    a_r2_half_even: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_size == SZ_HALF) |-> (acc_addr[0] == 1'b0));

    // R1: an odd address is always moved as a single byte
    a_r1_odd_byte: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_addr[0]) |-> (acc_size == SZ_BYTE));

    // R7: buffer writes happen only on acknowledged device reads
    a_r7_we_read_only: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (acc_req && acc_ack && !acc_wr && buf_be != '0));

    // R5: after an acknowledge the next address moves forward
    a_r5_advance: assert property (@(posedge clk) disable iff (rst)
        (acc_req && acc_ack) |=> (acc_addr != $past(acc_addr)));

endmodule

// File: tb/sim_xfer_splitter.sv
module sim_xfer_splitter;
    localparam int AW = 16;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0, go_wr = 1'b0;
    logic [AW-1:0] go_addr = '0;
    logic [LW-1:0] go_len = '0;
    logic          busy, done, acc_req, acc_wr, acc_ack = 1'b0, buf_we;
    logic [1:0]    acc_size;
    logic [AW-1:0] acc_addr;
    logic [31:0]   acc_wdata, acc_rdata = '0, buf_word, buf_wdata;
    logic [3:0]    buf_be;

    logic [7:0] mem [0:511];
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    assign buf_word = {mem[{acc_addr[8:2], 2'd3}], mem[{acc_addr[8:2], 2'd2}],
                       mem[{acc_addr[8:2], 2'd1}], mem[{acc_addr[8:2], 2'd0}]};

    xfer_splitter #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst(rst), .go(go), .go_wr(go_wr), .go_addr(go_addr),
        .go_len(go_len), .busy(busy), .done(done), .acc_req(acc_req),
        .acc_wr(acc_wr), .acc_size(acc_size), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_rdata(acc_rdata),
        .buf_word(buf_word), .buf_wdata(buf_wdata), .buf_be(buf_be),
        .buf_we(buf_we)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'(a * 3 + 1);
    endfunction

    function automatic logic [7:0] dev_byte(int a);
        return 8'(a) ^ 8'h5C;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_xfer(int addr, int len, bit wr, int seed, bit poke);
        int ea = addr, el = len, idx = 0, w = -1, n = 0, es = 0, guard = 0;
        string tag;
        for (int a = 0; a < 512; a++) mem[a] = init_byte(a);
        @(negedge clk);
        go = 1'b1; go_wr = wr; go_addr = AW'(addr); go_len = LW'(len);
        @(negedge clk);
        go = 1'b0;
        forever begin
            guard++;
            if (guard > 60) begin
                check(1'b0, "R11 transfer never finished", guard, 0);
                break;
            end
            if (el == 0) begin
                check(done && !acc_req, (len == 0) ? "R9 zero-length done" : "R11 done pulse",
                      {done, acc_req}, 2'b10);
                break;
            end
            check(acc_req && !done && busy, "R10 access presented", {acc_req, done, busy}, 3'b101);
            if (!acc_req) break;
            if (w < 0) begin
                // expected size from the alignment rules (R1..R4)
                if (ea % 2 == 1) begin es = 0; tag = "R1 odd byte"; end
                else if (ea % 4 == 2) begin
                    es = (el >= 2) ? 1 : 0; tag = "R2 align half";
                end
                else if (el >= 4) begin es = 2; tag = "R3 body word"; end
                else begin es = (el >= 2) ? 1 : 0; tag = "R4 tail"; end
                n = (es == 2) ? 4 : (es == 1) ? 2 : 1;
                check(acc_size == 2'(es), tag, acc_size, es);
                check(acc_addr == AW'(ea), "R5 address", acc_addr, ea);
                check(acc_wr == wr, "R8 direction", acc_wr, wr);
                if (wr) begin
                    logic [31:0] ew = '0;
                    for (int i = 0; i < 4; i++)
                        if (i < n) ew[8*i +: 8] = mem[(ea + i) % 512];
                    check(acc_wdata == ew, "R6 write lanes", acc_wdata, ew);
                end
                w = (idx + seed) % 3;
                if (poke && idx == 0) begin
                    go = 1'b1; go_wr = ~wr; go_addr = AW'(addr + 64); go_len = LW'(3);
                end
            end
            if (w == 0) begin
                acc_ack = 1'b1;
                for (int i = 0; i < 4; i++)
                    acc_rdata[8*i +: 8] = (i < n) ? dev_byte(ea + i) : 8'hEE;
                #1;
                if (wr) begin
                    check(!buf_we, "R7 no buffer write on device write", buf_we, 0);
                end else begin
                    logic [3:0] eb;
                    eb = 4'(((1 << n) - 1) << (ea % 4));
                    check(buf_we && buf_be == eb, "R7 read enables", {buf_we, buf_be}, {1'b1, eb});
                    for (int j = 0; j < 4; j++)
                        if (buf_be[j]) mem[{acc_addr[8:2], 2'(j)}] = buf_wdata[8*j +: 8];
                end
                ea += n; el -= n; idx++; w = -1;
            end else begin
                w--;
            end
            @(negedge clk);
            acc_ack = 1'b0;
            go = 1'b0;
        end
        if (!wr && len > 0) begin
            int mism = 0;
            for (int a = addr - 4; a < addr + len + 4; a++) begin
                logic [7:0] e;
                e = (a >= addr && a < addr + len) ? dev_byte(a) : init_byte(a);
                if (mem[a % 512] != e) mism++;
            end
            check(mism == 0, "R7 read data landed", mism, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !acc_req, "R11 reset state", {busy, done, acc_req}, 0);
        rst = 1'b0;
        // sweep start offsets, lengths and both directions (R8 same rules)
        for (int off = 0; off < 8; off++)
            for (int len = 0; len < 14; len++)
                for (int d = 0; d < 2; d++)
                    run_xfer(256 + off, len, d[0], off + len, (len % 3) == 1);
        // longer bodies, including a go poke while busy (R12)
        run_xfer(257, 37, 1'b1, 0, 1'b1);
        run_xfer(258, 40, 1'b0, 1, 1'b1);
        run_xfer(259, 1, 1'b0, 2, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule